// File: doc/BRIEF.md
# Lockable Watchdog with NMI Arbitration

This block guards against runaway software. Once armed, a counter advances on every system clock. Software must restart it with a clear strobe before the selected interval runs out. If it does not, the block raises a watchdog request that cannot be masked. There are four intervals, all of them power-of-two clock counts. Arming is one-way. After the watchdog is armed, neither the enable nor the interval can be changed, and only a reset returns the block to the idle state.

The block also merges the watchdog request with requests from an external non-maskable interrupt pin. Each source has its own pending flag. The combined request is high while either flag is set, and a source identifier names the flag being presented. When both are pending, a priority setting decides which one is presented first. An acknowledge clears only the flag being presented, so the other source stays pending. Software may change the priority at any time.

A `SHIFT` parameter subtracts a constant from every interval exponent, which shortens the intervals for simulation. With `SHIFT = 0` the intervals are 2^17, 2^19, 2^20 and 2^21 clocks.

Top module: `runaway_guard`

## Requirements
- R1: After reset the block is disarmed. `wdt_req` and `nmi_req` are 0, and without a write that arms it the block raises no watchdog request.
- R2: `cfg_interval` chooses the interval as 2^(E-SHIFT) clocks, with E = 17 for code 0, 19 for code 1, 20 for code 2 and 21 for code 3. `wdt_req` rises exactly that many clock edges after the edge that arms the block with `cfg_we=1` and `cfg_enable=1`.
- R3: Once armed, a write with `cfg_enable=0` has no effect, and the watchdog keeps timing out.
- R4: Once armed, a write to the interval field has no effect, and the interval chosen at arming stays in force.
- R5: A `kick` at any edge restarts the count, so the next request comes one full interval after that edge. A `kick` in the cycle that would otherwise overflow suppresses that request.
- R6: After an overflow the count restarts from zero at that same edge. If software does not kick, the next overflow comes one interval after the previous one.
- R7: A one-cycle pulse on `nmi_pin_req` sets the pin's pending flag. From the next cycle, `nmi_req` is 1 and `nmi_src` is 0 (pin).
- R8: When both flags are pending, `nmi_src` is 1 (watchdog) if `cfg_wdt_first` was written as 1, and 0 (pin) otherwise.
- R9: `nmi_ack` clears only the flag presented by `nmi_src`. The other flag stays pending and is presented next. `wdt_req` reflects the watchdog's pending flag.
- R10: The priority setting is written on every `cfg_we`, whether or not the block is armed, and it takes effect on the presentation in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Arm request, honoured only while disarmed |
| cfg_interval | input | 2 | Interval code, honoured only while disarmed |
| cfg_wdt_first | input | 1 | 1 gives the watchdog priority, 0 gives the pin priority |
| kick | input | 1 | Clear strobe from software |
| nmi_pin_req | input | 1 | External NMI request pulse |
| nmi_ack | input | 1 | Acknowledge of the presented request |
| wdt_req | output | 1 | Watchdog request pending |
| nmi_req | output | 1 | Combined non-maskable request |
| nmi_src | output | 1 | Presented source: 1 watchdog, 0 pin |

## Verification
The bench builds the block with `SHIFT = 13`, which gives intervals of 16, 64, 128 and 256 clocks. At that size every interval code can be timed to the exact edge. For the shortest interval, a kick is swept across every offset, including the overflow cycle itself. The lock, the restart after an overflow and both priority orders can all be exercised in a few thousand cycles.

// File: rtl/rg_pkg.sv
package rg_pkg;
  localparam int unsigned RG_MAX_EXP = 21;
  localparam int unsigned RG_NUM_IVAL = 4;

  typedef enum logic [1:0] {
    IVAL_17 = 2'd0,
    IVAL_19 = 2'd1,
    IVAL_20 = 2'd2,
    IVAL_21 = 2'd3
  } rg_ival_e;

  typedef enum logic {
    SRC_PIN = 1'b0,
    SRC_WDT = 1'b1
  } rg_src_e;

  // Unscaled interval exponent for each code.
  function automatic int unsigned rg_exp(input int unsigned code);
    case (code)
      0:       rg_exp = 17;
      1:       rg_exp = 19;
      2:       rg_exp = 20;
      default: rg_exp = 21;
    endcase
  endfunction
endpackage

// File: rtl/rg_rst_sync.sv
module rg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rg_cfg_lock.sv
module rg_cfg_lock
  import rg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_enable,
  input  logic [1:0] cfg_interval,
  input  logic       cfg_wdt_first,
  output logic       en_o,
  output logic [1:0] ival_o,
  output logic       wdt_first_o
);
  logic     en_q, en_d;
  rg_ival_e ival_q, ival_d;
  logic     wf_q, wf_d;

  // Next state: priority is always writable; enable and interval only while disarmed.
  always_comb begin
    en_d   = en_q;
    ival_d = ival_q;
    wf_d   = wf_q;
    if (cfg_we) begin
      wf_d = cfg_wdt_first;
      if (!en_q) begin
        en_d   = cfg_enable;
        ival_d = rg_ival_e'(cfg_interval);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ival_q <= IVAL_17;
      wf_q   <= 1'b0;
    end else if (cfg_we) begin
      en_q   <= en_d;
      ival_q <= ival_d;
      wf_q   <= wf_d;
    end
  end

  assign en_o        = en_q;
  assign ival_o      = ival_q;
  assign wdt_first_o = wf_q;
endmodule

// File: rtl/rg_interval_ctr.sv
module rg_interval_ctr
  import rg_pkg::*;
#(
  parameter int unsigned SHIFT = 0,
  parameter int unsigned CW    = RG_MAX_EXP - SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    ival,
  input  logic          kick,
  output logic          ovf_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] term [RG_NUM_IVAL];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hit;
  logic          cnt_ce;

  // Terminal count (interval - 1) for every code.
  for (genvar g = 0; g < RG_NUM_IVAL; g++) begin : g_term
    localparam int unsigned EXP = rg_exp(g) - SHIFT;
    assign term[g] = CW'((32'd1 << EXP) - 32'd1);
  end

  assign hit   = en && (cnt_q == term[ival]);
  assign ovf_o = hit && !kick;          // a clear in the overflow cycle wins

  always_comb begin
    if (!en || kick || hit) cnt_d = '0;
    else                    cnt_d = cnt_q + CW'(1);
  end

  assign cnt_ce = en || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rg_nmi_arb.sv
module rg_nmi_arb
  import rg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_set,
  input  logic pin_set,
  input  logic ack,
  input  logic wdt_first,
  output logic wdt_pend_o,
  output logic pin_pend_o,
  output logic req_o,
  output logic src_o
);
  logic    wdt_q, wdt_d;
  logic    pin_q, pin_d;
  logic    sel_wdt;
  rg_src_e src;

  assign sel_wdt = wdt_q && (!pin_q || wdt_first);
  assign src     = sel_wdt ? SRC_WDT : SRC_PIN;

  // A new request in the same cycle as its acknowledge keeps the flag set.
  always_comb begin
    wdt_d = wdt_set || (wdt_q && !(ack && sel_wdt));
    pin_d = pin_set || (pin_q && !(ack && !sel_wdt));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdt_q <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      wdt_q <= wdt_d;
      pin_q <= pin_d;
    end
  end

  assign wdt_pend_o = wdt_q;
  assign pin_pend_o = pin_q;
  assign req_o      = wdt_q || pin_q;
  assign src_o      = src;
endmodule

// File: rtl/runaway_guard.sv
module runaway_guard
  import rg_pkg::*;
#(
  parameter int unsigned SHIFT = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_enable,
  input  logic [1:0] cfg_interval,
  input  logic       cfg_wdt_first,
  input  logic       kick,
  input  logic       nmi_pin_req,
  input  logic       nmi_ack,
  output logic       wdt_req,
  output logic       nmi_req,
  output logic       nmi_src
);
  localparam int unsigned CW = RG_MAX_EXP - SHIFT;

  logic          rst_sync_n;
  logic          en_q;
  logic [1:0]    ival_q;
  logic          wfirst_q;
  logic          ovf;
  logic [CW-1:0] cnt;
  logic          pin_pend;

  rg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rg_cfg_lock u_cfg (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .cfg_we        (cfg_we),
    .cfg_enable    (cfg_enable),
    .cfg_interval  (cfg_interval),
    .cfg_wdt_first (cfg_wdt_first),
    .en_o          (en_q),
    .ival_o        (ival_q),
    .wdt_first_o   (wfirst_q)
  );

  rg_interval_ctr #(.SHIFT(SHIFT), .CW(CW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (en_q),
    .ival  (ival_q),
    .kick  (kick),
    .ovf_o (ovf),
    .cnt_o (cnt)
  );

  rg_nmi_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wdt_set    (ovf),
    .pin_set    (nmi_pin_req),
    .ack        (nmi_ack),
    .wdt_first  (wfirst_q),
    .wdt_pend_o (wdt_req),
    .pin_pend_o (pin_pend),
    .req_o      (nmi_req),
    .src_o      (nmi_src)
  );
endmodule

// File: rtl/runaway_guard_chk.sv
module runaway_guard_chk #(
  parameter int unsigned CW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_q,
  input logic [1:0]    ival_q,
  input logic          wfirst_q,
  input logic [CW-1:0] cnt,
  input logic          ovf,
  input logic          kick,
  input logic          nmi_pin_req,
  input logic          nmi_ack,
  input logic          wdt_req,
  input logic          pin_pend,
  input logic          nmi_req,
  input logic          nmi_src
);
  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !wdt_req);

  a_r3_enable_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);

  a_r4_interval_held: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(ival_q));

  a_r5_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && en_q) |=> (cnt == '0) && !$rose(wdt_req));

  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt == '0) && wdt_req);

  a_r7_pin_pends: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pin_req |=> nmi_req);

  a_r8_wdt_first: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_req && pin_pend && wfirst_q) |-> nmi_src);

  a_r8_pin_first: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_req && pin_pend && !wfirst_q) |-> !nmi_src);

  a_r9_ack_wdt: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ack && nmi_src && wdt_req && !ovf) |=> !wdt_req);

  a_r9_ack_keeps_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ack && nmi_src && pin_pend) |=> nmi_req);
endmodule

bind runaway_guard runaway_guard_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .en_q        (en_q),
  .ival_q      (ival_q),
  .wfirst_q    (wfirst_q),
  .cnt         (cnt),
  .ovf         (ovf),
  .kick        (kick),
  .nmi_pin_req (nmi_pin_req),
  .nmi_ack     (nmi_ack),
  .wdt_req     (wdt_req),
  .pin_pend    (pin_pend),
  .nmi_req     (nmi_req),
  .nmi_src     (nmi_src)
);

// File: tb/runaway_guard_bench.sv
module runaway_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SHIFT      = 13;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we, cfg_enable, cfg_wdt_first, kick, nmi_pin_req, nmi_ack;
  logic [1:0] cfg_interval;
  logic       wdt_req, nmi_req, nmi_src;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  runaway_guard #(.SHIFT(SHIFT)) u_runaway_guard (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
    .cfg_interval(cfg_interval), .cfg_wdt_first(cfg_wdt_first), .kick(kick),
    .nmi_pin_req(nmi_pin_req), .nmi_ack(nmi_ack), .wdt_req(wdt_req),
    .nmi_req(nmi_req), .nmi_src(nmi_src)
  );

  function automatic int lim(input int code);
    int e;
    case (code)
      0: e = 17; 1: e = 19; 2: e = 20; default: e = 21;
    endcase
    return 1 << (e - SHIFT);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; cfg_we = 0; cfg_enable = 0; cfg_interval = 0; cfg_wdt_first = 0;
    kick = 0; nmi_pin_req = 0; nmi_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // All stimulus tasks are entered at a falling edge and return at the next one.
  task automatic cfg_write(input bit en, input int code, input bit wf);
    cfg_we = 1; cfg_enable = en; cfg_interval = 2'(code); cfg_wdt_first = wf;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_kick();
    kick = 1; @(negedge clk); kick = 0;
  endtask

  task automatic pulse_pin();
    nmi_pin_req = 1; @(negedge clk); nmi_pin_req = 0;
  endtask

  task automatic pulse_ack();
    nmi_ack = 1; @(negedge clk); nmi_ack = 0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (n < 2000) begin
      @(negedge clk);
      n++;
      if (wdt_req) break;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    // R1: reset state and no request while disarmed
    reset_dut();
    check(!wdt_req && !nmi_req, "R1 reset", int'({wdt_req, nmi_req}), 0);
    cfg_write(1'b0, 0, 1'b0);
    repeat (300) @(negedge clk);
    check(!wdt_req && !nmi_req, "R1 disarmed idle", int'({wdt_req, nmi_req}), 0);

    // R2: each interval code timed from the arming edge
    for (int code = 0; code < 4; code++) begin
      reset_dut();
      cfg_write(1'b1, code, 1'b0);
      measure(n);
      check(n == lim(code), $sformatf("R2 code %0d", code), n, lim(code));
    end

    // R5: kick at every offset, the last one being the overflow cycle
    for (int k = 1; k <= lim(0); k++) begin
      reset_dut();
      cfg_write(1'b1, 0, 1'b0);
      repeat (k - 1) @(negedge clk);
      pulse_kick();
      measure(n);
      check(n == lim(0), $sformatf("R5 kick offset %0d", k), n, lim(0));
    end

    // R6 / R9: acknowledge, then restart measured from the overflow
    reset_dut();
    cfg_write(1'b1, 0, 1'b0);
    measure(n);
    pulse_ack();
    check(!wdt_req && !nmi_req, "R9 ack clears watchdog", int'(wdt_req), 0);
    measure(n);
    check(n == lim(0) - 1, "R6 next overflow", n, lim(0) - 1);

    // R3: disarm attempt ignored; R4: interval change ignored
    reset_dut();
    cfg_write(1'b1, 0, 1'b0);
    cfg_write(1'b0, 0, 1'b0);
    pulse_kick();
    measure(n);
    check(n == lim(0), "R3 still armed", n, lim(0));
    pulse_ack();
    cfg_write(1'b1, 3, 1'b0);
    pulse_kick();
    measure(n);
    check(n == lim(0), "R4 interval locked", n, lim(0));

    // R7: pin request alone
    reset_dut();
    pulse_pin();
    check(nmi_req && !nmi_src && !wdt_req, "R7 pin pending",
          int'({nmi_req, nmi_src, wdt_req}), 4);
    pulse_ack();
    check(!nmi_req, "R7 pin acked", int'(nmi_req), 0);

    // R8 / R9: watchdog first
    reset_dut();
    cfg_write(1'b1, 0, 1'b1);
    measure(n);
    pulse_pin();
    check(nmi_src, "R8 watchdog first", int'(nmi_src), 1);
    pulse_ack();
    check(!wdt_req && nmi_req && !nmi_src, "R9 pin kept",
          int'({wdt_req, nmi_req, nmi_src}), 2);
    pulse_ack();
    check(!nmi_req, "R9 all acked", int'(nmi_req), 0);

    // R8 / R9 / R10: pin first, then priority rewritten while armed
    reset_dut();
    cfg_write(1'b1, 0, 1'b0);
    measure(n);
    pulse_pin();
    check(!nmi_src, "R8 pin first", int'(nmi_src), 0);
    pulse_ack();
    check(wdt_req && nmi_src, "R9 watchdog kept", int'({wdt_req, nmi_src}), 3);
    pulse_pin();
    check(!nmi_src, "R8 pin first again", int'(nmi_src), 0);
    cfg_write(1'b1, 0, 1'b1);
    check(nmi_src, "R10 priority rewritten", int'(nmi_src), 1);

    finish_run();
  end
endmodule